// File: doc/BRIEF.md
# Multi-Mailbox Message Reassembler

This block takes message segments arriving from a serial fabric and rebuilds complete Ethernet payloads from them. Every segment names a mailbox, its own index within the message, and the total segment count of the message. Each mailbox has a private reassembly context with its own buffer area. Messages bound for different mailboxes can therefore arrive interleaved without mixing.

Segment data lands at a position set by its index, so the segments may arrive in any order. A mailbox is released for output only when both of these hold: every index below the message length has been received, and the sender's doorbell for that mailbox has been seen. The buffered payload then streams out as one frame, segment 0 first. A small lookup table, loaded per mailbox, supplies the destination station address that accompanies the frame. When several mailboxes are ready at the same time they are drained in rotating order. Framing, checksum generation and the fabric's physical and link layers are handled elsewhere.

Top module: `mbr_reassembler`

## Requirements
- R1: After reset, `out_valid` and `err_valid` are 0 and `seg_ready` is 1 for every mailbox.
- R2: A segment is exactly `SEG_BEATS` beats. Beat b of index i is stored at offset i*SEG_BEATS+b in its mailbox's buffer. The frame emits segments in ascending index order, whatever order they arrived in.
- R3: A frame for a mailbox starts only once indices 0..len-1 have all been received and a doorbell has been latched. The frame is len*SEG_BEATS beats long, and `out_last` is 1 on its final beat only.
- R4: A doorbell to a mailbox with no open message is ignored. A doorbell to a mailbox that is being drained is also ignored.
- R5: Messages to different mailboxes may be interleaved segment by segment, and each frame carries only its own mailbox's data.
- R6: A segment whose index is already recorded in its open context is discarded. Its data is not written and no error is raised.
- R7: If a segment's length differs from the length latched in its open context, the segment is dropped and the context is flushed, which clears its received map, its length and its doorbell. An error is reported with `err_code` = 1 and `err_mbox` set to that mailbox.
- R8: A segment is malformed when its length is 0, or its length exceeds `MAX_SEGS`, or its index is not below its length. A malformed segment is dropped with `err_code` = 2, and the context is left unchanged.
- R9: When several mailboxes are ready, the next frame goes to the first ready mailbox after the one granted last, searching upward with wrap-around. After reset the search starts at mailbox 0.
- R10: `out_dst` is the table entry of the frame's mailbox, captured when the frame starts. A table write during the frame does not change it, and the next frame uses the new entry.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output beat holds steady. A context is freed only after its last beat has been accepted. A segment that starts toward a mailbox being drained sees `seg_ready` = 0.
- R12: `err_valid` pulses for exactly one cycle, in the cycle after the final beat of the offending segment is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_valid | input | 1 | Segment beat valid |
| seg_ready | output | 1 | Segment beat accepted when high with valid |
| seg_mbox | input | $clog2(NUM_MBOX) | Target mailbox of the segment |
| seg_idx | input | $clog2(MAX_SEGS) | Segment index within the message |
| seg_len | input | $clog2(MAX_SEGS+1) | Message length in segments |
| seg_data | input | DATA_W | Segment beat payload |
| db_valid | input | 1 | Doorbell strobe |
| db_mbox | input | $clog2(NUM_MBOX) | Mailbox the doorbell refers to |
| map_we | input | 1 | Destination table write strobe |
| map_mbox | input | $clog2(NUM_MBOX) | Table entry to write |
| map_dst | input | DST_W | Destination address to store |
| out_valid | output | 1 | Frame beat valid |
| out_ready | input | 1 | Frame beat accepted when high with valid |
| out_data | output | DATA_W | Frame beat payload |
| out_last | output | 1 | Final beat of the frame |
| out_mbox | output | $clog2(NUM_MBOX) | Mailbox the frame came from |
| out_dst | output | DST_W | Destination address for the frame |
| err_valid | output | 1 | Error pulse |
| err_mbox | output | $clog2(NUM_MBOX) | Mailbox of the rejected segment |
| err_code | output | 2 | 1 = length mismatch, 2 = malformed |

## Verification
The assertions take for granted that every segment is sent as one unbroken run of exactly `SEG_BEATS` accepted beats. The header fields are read from the first beat only. The bench drives whole segments beat by beat. It keeps the header fields constant within a segment and raises `seg_valid` toward a draining mailbox only as a single probe beat that is never accepted. Doorbells and table writes are single-cycle strobes issued between segments or during a stalled output beat. The data word encodes mailbox, segment, beat and a message tag, so every misplaced or stale word is caught.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

   typedef enum logic [1:0] {
      ERR_NONE         = 2'd0,
      ERR_LEN_MISMATCH = 2'd1,
      ERR_MALFORMED    = 2'd2
   } err_code_e;

endpackage

// File: rtl/mbr_store.sv
module mbr_store #(
   parameter int DATA_W = 64,
   parameter int AW     = 11,
   localparam int DEPTH = 1 << AW
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/mbr_rr_arb.sv
module mbr_rr_arb #(
   parameter int N           = 16,
   parameter bit ROUND_ROBIN = 1'b1,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gidx,
   output logic          any
);

   assign any = |req;

   generate
      if (ROUND_ROBIN) begin : g_rr
         logic [IW-1:0] ptr_q;

         always_comb begin
            int  c;
            logic found;
            gnt   = '0;
            gidx  = '0;
            found = 1'b0;
            for (int k = 1; k <= N; k++) begin
               c = (int'(ptr_q) + k) % N;
               if (!found && req[c]) begin
                  found  = 1'b1;
                  gnt[c] = 1'b1;
                  gidx   = IW'(c);
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ptr_q <= IW'(N - 1);
            else if (adv) ptr_q <= gidx;
         end
      end else begin : g_fixed
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, adv};

         always_comb begin
            gnt  = '0;
            gidx = '0;
            for (int k = N - 1; k >= 0; k--) begin
               if (req[k]) begin
                  gnt    = '0;
                  gnt[k] = 1'b1;
                  gidx   = IW'(k);
               end
            end
         end
      end
   endgenerate

   assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_grant_requested_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);

endmodule

// File: rtl/mbr_ctx.sv
module mbr_ctx #(
   parameter int MAX_SEGS = 4,
   parameter int IDX_W    = 2,
   parameter int LEN_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_i,
   input  logic                flush_i,
   input  logic [IDX_W-1:0]    idx_i,
   input  logic [LEN_W-1:0]    len_i,
   input  logic                db_i,
   input  logic                grant_i,
   input  logic                release_i,
   output logic                open_o,
   output logic [LEN_W-1:0]    len_o,
   output logic [MAX_SEGS-1:0] map_o,
   output logic                pend_o,
   output logic                drain_o
);

   logic                open_q, db_q, drain_q;
   logic [LEN_W-1:0]    len_q;
   logic [MAX_SEGS-1:0] map_q, need;

   always_comb begin
      for (int k = 0; k < MAX_SEGS; k++) need[k] = (k < int'(len_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         db_q    <= 1'b0;
         drain_q <= 1'b0;
         len_q   <= '0;
         map_q   <= '0;
      end else if (release_i || flush_i) begin
         open_q  <= 1'b0;
         db_q    <= 1'b0;
         drain_q <= 1'b0;
         len_q   <= '0;
         map_q   <= '0;
      end else begin
         if (set_i) begin
            open_q       <= 1'b1;
            len_q        <= len_i;
            map_q[idx_i] <= 1'b1;
         end
         if (db_i && open_q && !drain_q) db_q <= 1'b1;
         if (grant_i) drain_q <= 1'b1;
      end
   end

   assign open_o  = open_q;
   assign len_o   = len_q;
   assign map_o   = map_q;
   assign drain_o = drain_q;
   assign pend_o  = open_q && (map_q == need) && db_q && !drain_q;

   assert_map_within_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (map_q & ~need) == '0);
   assert_release_when_draining_R11: assert property (@(posedge clk) disable iff (!rst_n)
      release_i |-> drain_q);
   assert_grant_when_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i |-> pend_o);
   assert_no_set_while_draining_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |-> !drain_q);

endmodule

// File: rtl/mbr_reassembler.sv
module mbr_reassembler
   import mbr_pkg::*;
#(
   parameter int NUM_MBOX    = 16,
   parameter int MAX_SEGS    = 4,
   parameter int SEG_BEATS   = 32,
   parameter int DATA_W      = 64,
   parameter int DST_W       = 48,
   parameter bit ROUND_ROBIN = 1'b1,
   localparam int MB_W   = $clog2(NUM_MBOX),
   localparam int IDX_W  = $clog2(MAX_SEGS),
   localparam int LEN_W  = $clog2(MAX_SEGS + 1),
   localparam int BEAT_W = $clog2(SEG_BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_valid,
   output logic              seg_ready,
   input  logic [MB_W-1:0]   seg_mbox,
   input  logic [IDX_W-1:0]  seg_idx,
   input  logic [LEN_W-1:0]  seg_len,
   input  logic [DATA_W-1:0] seg_data,
   input  logic              db_valid,
   input  logic [MB_W-1:0]   db_mbox,
   input  logic              map_we,
   input  logic [MB_W-1:0]   map_mbox,
   input  logic [DST_W-1:0]  map_dst,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic [MB_W-1:0]   out_mbox,
   output logic [DST_W-1:0]  out_dst,
   output logic              err_valid,
   output logic [MB_W-1:0]   err_mbox,
   output logic [1:0]        err_code
);

   localparam int PW = IDX_W + BEAT_W;
   localparam int AW = MB_W + PW;

   generate
      if (NUM_MBOX < 2 || (1 << MB_W) != NUM_MBOX) begin : g_bad_mbox
         $error("NUM_MBOX must be a power of two >= 2");
      end
      if (MAX_SEGS < 2 || (1 << IDX_W) != MAX_SEGS) begin : g_bad_segs
         $error("MAX_SEGS must be a power of two >= 2");
      end
      if (SEG_BEATS < 2 || (1 << BEAT_W) != SEG_BEATS) begin : g_bad_beats
         $error("SEG_BEATS must be a power of two >= 2");
      end
      if (DATA_W < 1 || DST_W < 1) begin : g_bad_width
         $error("DATA_W and DST_W must be positive");
      end
   endgenerate

   // ---------------- context array ----------------
   logic [NUM_MBOX-1:0] set_v, flush_v, db_v, grant_v, release_v;
   logic [NUM_MBOX-1:0] open_v, pend_v, drain_v, req_v, gnt_v;
   logic [LEN_W-1:0]    len_a [NUM_MBOX];
   logic [MAX_SEGS-1:0] map_a [NUM_MBOX];

   // ---------------- segment intake ----------------
   logic [BEAT_W-1:0] in_beat_q;
   logic [MB_W-1:0]   h_mbox_q;
   logic [IDX_W-1:0]  h_idx_q;
   logic [LEN_W-1:0]  h_len_q;
   logic              first, acc, seg_end;
   logic [MB_W-1:0]   cur_mbox;
   logic [IDX_W-1:0]  cur_idx;
   logic [LEN_W-1:0]  cur_len;
   logic              bad_fmt, mism, dup, wr_ok;

   assign first    = (in_beat_q == '0);
   assign cur_mbox = first ? seg_mbox : h_mbox_q;
   assign cur_idx  = first ? seg_idx  : h_idx_q;
   assign cur_len  = first ? seg_len  : h_len_q;

   assign seg_ready = first ? !drain_v[seg_mbox] : 1'b1;
   assign acc       = seg_valid && seg_ready;
   assign seg_end   = acc && (in_beat_q == BEAT_W'(SEG_BEATS - 1));

   assign bad_fmt = (cur_len == '0) || (cur_len > LEN_W'(MAX_SEGS))
                    || (LEN_W'(cur_idx) >= cur_len);
   assign mism    = !bad_fmt && open_v[cur_mbox] && (cur_len != len_a[cur_mbox]);
   assign dup     = !bad_fmt && !mism && open_v[cur_mbox] && map_a[cur_mbox][cur_idx];
   assign wr_ok   = !bad_fmt && !mism && !dup;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_beat_q <= '0;
         h_mbox_q  <= '0;
         h_idx_q   <= '0;
         h_len_q   <= '0;
      end else if (acc) begin
         in_beat_q <= in_beat_q + 1'b1;
         if (first) begin
            h_mbox_q <= seg_mbox;
            h_idx_q  <= seg_idx;
            h_len_q  <= seg_len;
         end
      end
   end

   // ---------------- error reporting ----------------
   err_code_e err_code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_valid  <= 1'b0;
         err_mbox   <= '0;
         err_code_q <= ERR_NONE;
      end else begin
         err_valid <= seg_end && (bad_fmt || mism);
         if (seg_end && (bad_fmt || mism)) begin
            err_mbox   <= cur_mbox;
            err_code_q <= bad_fmt ? ERR_MALFORMED : ERR_LEN_MISMATCH;
         end
      end
   end

   assign err_code = err_code_q;

   // ---------------- destination table ----------------
   logic [DST_W-1:0] dst_q [NUM_MBOX];

   // ---------------- output engine ----------------
   logic              busy_q;
   logic [MB_W-1:0]   o_mbox_q;
   logic [LEN_W-1:0]  o_len_q;
   logic [PW-1:0]     o_pos_q;
   logic [DST_W-1:0]  o_dst_q;
   logic [MB_W-1:0]   gidx;
   logic              any_req, adv, out_acc;
   logic [IDX_W-1:0]  o_seg;
   logic [BEAT_W-1:0] o_beat;

   assign adv     = !busy_q && any_req;
   assign o_seg   = o_pos_q[PW-1:BEAT_W];
   assign o_beat  = o_pos_q[BEAT_W-1:0];
   assign out_valid = busy_q;
   assign out_last  = busy_q && (LEN_W'(o_seg) == (o_len_q - LEN_W'(1)))
                      && (o_beat == BEAT_W'(SEG_BEATS - 1));
   assign out_acc   = out_valid && out_ready;
   assign out_mbox  = o_mbox_q;
   assign out_dst   = o_dst_q;

   genvar m;
   generate
      for (m = 0; m < NUM_MBOX; m++) begin : g_ctx
         assign set_v[m]     = seg_end && wr_ok && (cur_mbox == MB_W'(m));
         assign flush_v[m]   = seg_end && mism  && (cur_mbox == MB_W'(m));
         assign db_v[m]      = db_valid && (db_mbox == MB_W'(m));
         assign grant_v[m]   = gnt_v[m] && adv;
         assign release_v[m] = out_acc && out_last && (o_mbox_q == MB_W'(m));
         assign req_v[m]     = pend_v[m]
                               && !(!first && (h_mbox_q == MB_W'(m)))
                               && !(first && seg_valid && (seg_mbox == MB_W'(m)));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 dst_q[m] <= '0;
            else if (map_we && (map_mbox == MB_W'(m)))  dst_q[m] <= map_dst;
         end

         mbr_ctx #(
            .MAX_SEGS (MAX_SEGS),
            .IDX_W    (IDX_W),
            .LEN_W    (LEN_W)
         ) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_v[m]),
            .flush_i   (flush_v[m]),
            .idx_i     (cur_idx),
            .len_i     (cur_len),
            .db_i      (db_v[m]),
            .grant_i   (grant_v[m]),
            .release_i (release_v[m]),
            .open_o    (open_v[m]),
            .len_o     (len_a[m]),
            .map_o     (map_a[m]),
            .pend_o    (pend_v[m]),
            .drain_o   (drain_v[m])
         );
      end
   endgenerate

   mbr_rr_arb #(
      .N           (NUM_MBOX),
      .ROUND_ROBIN (ROUND_ROBIN)
   ) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_v),
      .adv   (adv),
      .gnt   (gnt_v),
      .gidx  (gidx),
      .any   (any_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         o_mbox_q <= '0;
         o_len_q  <= '0;
         o_pos_q  <= '0;
         o_dst_q  <= '0;
      end else if (adv) begin
         busy_q   <= 1'b1;
         o_mbox_q <= gidx;
         o_len_q  <= len_a[gidx];
         o_pos_q  <= '0;
         o_dst_q  <= dst_q[gidx];
      end else if (out_acc) begin
         if (out_last) busy_q <= 1'b0;
         else          o_pos_q <= o_pos_q + 1'b1;
      end
   end

   // ---------------- payload buffer ----------------
   mbr_store #(
      .DATA_W (DATA_W),
      .AW     (AW)
   ) u_store (
      .clk   (clk),
      .we    (acc && wr_ok),
      .waddr ({cur_mbox, cur_idx, in_beat_q}),
      .wdata (seg_data),
      .raddr ({o_mbox_q, o_pos_q}),
      .rdata (out_data)
   );

   assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
                                  && $stable(out_mbox) && $stable(out_dst));
   assert_no_write_draining_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && wr_ok) |-> !drain_v[cur_mbox]);
   assert_err_after_seg_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> $past(seg_end));
   assert_idle_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_acc && out_last |=> !out_valid);
   assert_frame_mbox_draining_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> drain_v[out_mbox]);

endmodule

// File: tb/tb_mbr_reassembler.sv
module tb_mbr_reassembler;

   localparam int CLK_PERIOD = 10;
   localparam int NMB = 4;
   localparam int MS  = 4;
   localparam int SB  = 4;
   localparam int DW  = 16;
   localparam int DSW = 48;
   localparam logic [DSW-1:0] DST_BASE = 48'h02AB_CD00_0000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           seg_valid = 1'b0, seg_ready;
   logic [1:0]     seg_mbox = '0;
   logic [1:0]     seg_idx = '0;
   logic [2:0]     seg_len = '0;
   logic [DW-1:0]  seg_data = '0;
   logic           db_valid = 1'b0;
   logic [1:0]     db_mbox = '0;
   logic           map_we = 1'b0;
   logic [1:0]     map_mbox = '0;
   logic [DSW-1:0] map_dst = '0;
   logic           out_valid, out_ready = 1'b0, out_last;
   logic [DW-1:0]  out_data;
   logic [1:0]     out_mbox;
   logic [DSW-1:0] out_dst;
   logic           err_valid;
   logic [1:0]     err_mbox;
   logic [1:0]     err_code;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mbr_reassembler #(
      .NUM_MBOX (NMB), .MAX_SEGS (MS), .SEG_BEATS (SB),
      .DATA_W (DW), .DST_W (DSW), .ROUND_ROBIN (1'b1)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .seg_valid (seg_valid), .seg_ready (seg_ready), .seg_mbox (seg_mbox),
      .seg_idx (seg_idx), .seg_len (seg_len), .seg_data (seg_data),
      .db_valid (db_valid), .db_mbox (db_mbox),
      .map_we (map_we), .map_mbox (map_mbox), .map_dst (map_dst),
      .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
      .out_last (out_last), .out_mbox (out_mbox), .out_dst (out_dst),
      .err_valid (err_valid), .err_mbox (err_mbox), .err_code (err_code)
   );

   function automatic logic [DW-1:0] pat(int m, int s, int b, int t);
      return {4'(m), 4'(s), 4'(b), 4'(t)};
   endfunction

   function automatic logic [DSW-1:0] dst_of(int m);
      return DST_BASE + DSW'(m);
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic map_write(int m, logic [DSW-1:0] d);
      @(negedge clk);
      map_we = 1'b1; map_mbox = 2'(m); map_dst = d;
      @(negedge clk);
      map_we = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; seg_valid = 1'b0; db_valid = 1'b0; map_we = 1'b0; out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int m = 0; m < NMB; m++) map_write(m, dst_of(m));
   endtask

   task automatic doorbell(int m);
      @(negedge clk);
      db_valid = 1'b1; db_mbox = 2'(m);
      @(negedge clk);
      db_valid = 1'b0;
   endtask

   // exp_err: 0 none, 1 length mismatch, 2 malformed
   task automatic send_seg(int m, int idx, int len, int tag, int exp_err, string req);
      for (int b = 0; b < SB; b++) begin
         @(negedge clk);
         seg_valid = 1'b1; seg_mbox = 2'(m); seg_idx = 2'(idx); seg_len = 3'(len);
         seg_data = pat(m, idx, b, tag);
         while (!seg_ready) @(negedge clk);
      end
      @(negedge clk);
      seg_valid = 1'b0;
      if (exp_err == 0) begin
         chk(err_valid == 1'b0, req, 64'(err_valid), 64'd0);
      end else begin
         chk(err_valid && err_code == 2'(exp_err) && err_mbox == 2'(m), req,
             {err_valid, 2'b0, err_code, 2'b0, err_mbox},
             {1'b1, 2'b0, 2'(exp_err), 2'b0, 2'(m)});
         @(negedge clk);
         chk(err_valid == 1'b0, "R12 pulse width", 64'(err_valid), 64'd0);
      end
   endtask

   task automatic quiet(int n, string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, req, 64'(out_valid), 64'd0);
      end
   endtask

   task automatic collect(int m, int len, int tag, logic [DSW-1:0] dst, bit stall, string req);
      int nb;
      logic [DW-1:0] held;
      nb = len * SB;
      @(negedge clk);
      out_ready = 1'b1;
      while (!out_valid) @(negedge clk);
      for (int j = 0; j < nb; j++) begin
         chk(out_data == pat(m, j / SB, j % SB, tag) && out_mbox == 2'(m)
             && out_dst == dst && out_last == (j == nb - 1), req,
             {out_last, 1'b0, out_mbox, out_dst[11:0], out_data},
             {(j == nb - 1), 1'b0, 2'(m), dst[11:0], pat(m, j / SB, j % SB, tag)});
         if (stall && j == 1) begin
            out_ready = 1'b0;
            held = out_data;
            seg_valid = 1'b1; seg_mbox = 2'(m); seg_idx = '0; seg_len = 3'd1;
            map_we = 1'b1; map_mbox = 2'(m); map_dst = ~dst;
            chk(seg_ready == 1'b0, "R11 intake stalled while draining", 64'(seg_ready), 64'd0);
            for (int s = 0; s < 3; s++) begin
               @(negedge clk);
               seg_valid = 1'b0; map_we = 1'b0;
               chk(out_valid && out_data == held && out_dst == dst,
                   "R11 R10 beat held under backpressure",
                   {out_valid, out_dst[15:0], out_data}, {1'b1, dst[15:0], held});
            end
            out_ready = 1'b1;
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(out_valid == 1'b0, "R11 idle after last beat", 64'(out_valid), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk(seg_ready && !out_valid && !err_valid, "R1 reset state",
          {seg_ready, out_valid, err_valid}, 3'b100);

      // R2 out-of-order placement, R3 waits for doorbell
      send_seg(1, 2, 3, 1, 0, "R2");
      send_seg(1, 0, 3, 1, 0, "R2");
      send_seg(1, 1, 3, 1, 0, "R2");
      quiet(5, "R3 complete without doorbell holds");
      doorbell(1);
      collect(1, 3, 1, dst_of(1), 1'b0, "R2 R3 ordered frame");

      // R3 doorbell latched before completion
      send_seg(0, 0, 2, 2, 0, "R3");
      doorbell(0);
      quiet(4, "R3 incomplete message holds");
      send_seg(0, 1, 2, 2, 0, "R3");
      collect(0, 2, 2, dst_of(0), 1'b0, "R3 release on completion");

      // R4 doorbell to idle mailbox ignored
      doorbell(3);
      send_seg(3, 0, 1, 3, 0, "R4");
      quiet(4, "R4 stale doorbell ignored");
      doorbell(3);
      collect(3, 1, 3, dst_of(3), 1'b0, "R4 frame after real doorbell");

      // R5 interleaved mailboxes
      send_seg(2, 0, 2, 5, 0, "R5");
      send_seg(3, 1, 2, 6, 0, "R5");
      send_seg(2, 1, 2, 5, 0, "R5");
      send_seg(3, 0, 2, 6, 0, "R5");
      doorbell(2);
      collect(2, 2, 5, dst_of(2), 1'b0, "R5 mailbox 2 frame");
      doorbell(3);
      collect(3, 2, 6, dst_of(3), 1'b0, "R5 mailbox 3 frame");

      // R6 duplicate index ignored
      send_seg(1, 0, 2, 7, 0, "R6");
      send_seg(1, 0, 2, 8, 0, "R6 duplicate raises no error");
      send_seg(1, 1, 2, 7, 0, "R6");
      doorbell(1);
      collect(1, 2, 7, dst_of(1), 1'b0, "R6 original data kept");

      // R7 length mismatch flushes context and doorbell
      send_seg(2, 0, 3, 9, 0, "R7");
      doorbell(2);
      send_seg(2, 1, 2, 9, 1, "R7 mismatch error");
      send_seg(2, 0, 2, 10, 0, "R7");
      send_seg(2, 1, 2, 10, 0, "R7");
      quiet(4, "R7 doorbell cleared by flush");
      doorbell(2);
      collect(2, 2, 10, dst_of(2), 1'b0, "R7 fresh message after flush");

      // R8 malformed segments dropped, context kept
      send_seg(0, 0, 2, 11, 0, "R8");
      send_seg(0, 0, 0, 12, 2, "R8 zero length");
      send_seg(0, 1, 5, 12, 2, "R8 length above limit");
      send_seg(0, 3, 2, 12, 2, "R8 index not below length");
      send_seg(0, 1, 2, 11, 0, "R8");
      doorbell(0);
      collect(0, 2, 11, dst_of(0), 1'b0, "R8 context unchanged");

      // R10 R11 backpressure and mid-frame table write
      send_seg(3, 0, 2, 12, 0, "R10");
      send_seg(3, 1, 2, 12, 0, "R10");
      doorbell(3);
      collect(3, 2, 12, dst_of(3), 1'b1, "R10 R11 frame under stall");
      send_seg(3, 0, 1, 13, 0, "R10");
      doorbell(3);
      collect(3, 1, 13, ~dst_of(3), 1'b0, "R10 next frame uses new entry");

      // R9 rotating order among several ready mailboxes
      do_reset();
      for (int m = 0; m < NMB; m++) send_seg(m, 0, 1, m + 4, 0, "R9");
      doorbell(2);
      doorbell(0);
      doorbell(1);
      doorbell(3);
      collect(2, 1, 6, dst_of(2), 1'b0, "R9 first grant");
      collect(3, 1, 7, dst_of(3), 1'b0, "R9 rotation after 2");
      collect(0, 1, 4, dst_of(0), 1'b0, "R9 wrap to 0");
      collect(1, 1, 5, dst_of(1), 1'b0, "R9 then 1");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule